// File: doc/BRIEF.md
# Two-Queue Conversion Command Sequencer

This block drives an analog-to-digital converter from a table of 64 conversion commands. Each command names one of eight input channels and one of four sample times. The table holds two queues. Queue 1 owns the entries from index 0 up to, but not including, a programmable split index. Queue 2 owns the entries from the split index to the top of the table. The sequencer walks through a queue one entry at a time. For each entry it holds a request to the converter until the converter returns a 10-bit result, then stores that result in a result table at the same index as the command.

A queue can be started by a software pulse, by a rising edge on its external trigger, by its external trigger used as a gate, or by an internal free-running interval timer. Each queue scans once or continuously. A pause flag in a command splits a queue into subqueues. Each queue reports completion and pause with one-cycle interrupt pulses and shows its current entry on a pointer output. Queue 1 takes priority over queue 2. The priority decision is made only between conversions, so a queue 2 scan that queue 1 interrupts picks up at its saved entry. Results are read back through a combinational port in one of three alignments.

Top module: `adcq_seq`

## Requirements
- R1: A command word is {eoq[6], pause[5], samp[4:3], chan[2:0]}. Each converted entry raises `conv_req_o` with that entry's channel and sample time, holding them steady until `conv_done_i`. The returned value is stored at the entry's own index.
- R2: `res_data_o` shows the stored result r of entry `res_addr_i` in the format `res_fmt_i` selects: 0 gives {6'b0, r}, 1 gives {~r[9], r[8:0], 6'b0}, 2 gives {r, 6'b0}, and 3 behaves like 0.
- R3: Queue 1 spans entries 0 to `q2_begin_i`-1 and queue 2 spans `q2_begin_i` to 63. A queue ends at an entry with eoq set, which is not converted, or after converting the last entry of its span. A split index of 0 disables queue 1.
- R4: When a queue ends, its bit of `complete_irq_o` pulses for one cycle and its pointer returns to the queue's first entry. At most one queue completes in any cycle.
- R5: After converting an entry with pause set that is not the last entry of its span, the queue's `pause_irq_o` bit pulses, without a completion. Its pointer moves to the next entry and the queue waits for a new trigger.
- R6: In single-scan mode (`q_cont_i` bit 0), a queue ignores triggers after it completes, until its enable goes low and then high again.
- R7: In continuous-scan mode, each trigger after a completion starts a new scan.
- R8: Source 1 (edge) starts a queue on a rising edge of its `ext_trig_i` bit. Holding the input high does not start another scan.
- R9: Source 2 (gate) runs the queue while its `ext_trig_i` bit is high. When the gate drops, the conversion in flight finishes and the pointer then holds. When the gate rises again, conversion resumes from that entry.
- R10: Source 3 (timer) starts a queue on an internal tick that recurs every `timer_period_i`+1 cycles. Source 0 is the `sw_trig_i` pulse.
- R11: Between conversions, queue 1 is served whenever it is running. Queue 2 then resumes at the entry after its last converted one.
- R12: After reset no request or interrupt is active and the queue 1 pointer is 0. While a queue is disabled, its pointer holds the queue's first entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command table write strobe |
| cmd_addr_i | input | 6 | Command table write index |
| cmd_wdata_i | input | 7 | Command word {eoq, pause, samp[1:0], chan[2:0]} |
| q2_begin_i | input | 6 | First entry of queue 2 |
| q_en_i | input | 2 | Queue enables, bit 0 is queue 1 |
| q_src_i | input | 4 | Trigger source, [1:0] queue 1, [3:2] queue 2 (0 sw, 1 edge, 2 gate, 3 timer) |
| q_cont_i | input | 2 | Continuous-scan select per queue |
| sw_trig_i | input | 2 | Software start pulses |
| ext_trig_i | input | 2 | External trigger or gate per queue |
| timer_period_i | input | 16 | Interval timer period minus one |
| conv_req_o | output | 1 | Conversion request |
| conv_chan_o | output | 3 | Requested channel |
| conv_samp_o | output | 2 | Requested sample time |
| conv_done_i | input | 1 | Converter result valid pulse |
| conv_data_i | input | 10 | Converter result |
| res_fmt_i | input | 2 | Result read format |
| res_addr_i | input | 6 | Result read index |
| res_data_o | output | 16 | Formatted result |
| q1_ptr_o | output | 6 | Queue 1 current entry |
| q2_ptr_o | output | 6 | Queue 2 current entry |
| complete_irq_o | output | 2 | Queue completion pulses |
| pause_irq_o | output | 2 | Queue pause pulses |

## Verification
The hardest case to reach is queue 1 taking over while a queue 2 conversion is in flight. This needs a queue 1 trigger that lands after queue 2 has issued a request but before that request is answered. The bench watches the rising edges of the request and pulses queue 1's software start at the falling clock edge just after queue 2's third request appears. It then checks the full order of channel and sample-time pairs: three queue 2 entries, all of queue 1, then the remaining queue 2 entries. The gate stop is reached the same way. The gate is dropped in the middle of a scan, and the bench checks that the pointer stops at an entry inside the span and that the next request after the gate rises comes from that same entry.

// File: rtl/adcq_pkg.sv
package adcq_pkg;
  localparam int CH_W = 3;
  localparam int ST_W = 2;

  typedef struct packed {
    logic            eoq;
    logic            pause;
    logic [ST_W-1:0] samp;
    logic [CH_W-1:0] chan;
  } cmd_t;

  localparam int CMD_W = $bits(cmd_t);

  typedef enum logic [1:0] {
    SRC_SW   = 2'd0,
    SRC_EDGE = 2'd1,
    SRC_GATE = 2'd2,
    SRC_TMR  = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    FMT_RU = 2'd0,
    FMT_LS = 2'd1,
    FMT_LU = 2'd2
  } fmt_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } st_e;
endpackage

// File: rtl/adcq_timer.sv
module adcq_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TMR_W-1:0] period_i,
  output logic             tick_o
);
  logic [TMR_W-1:0] cnt_q;

  assign tick_o = (cnt_q == period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + TMR_W'(1);
  end
endmodule

// File: rtl/adcq_trig.sv
module adcq_trig
  import adcq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] src_i,
  input  logic       cont_i,
  input  logic       sw_i,
  input  logic       ext_i,
  input  logic       tick_i,
  input  logic       stop_i,
  input  logic       done_i,
  output logic       run_o
);
  logic en_d, ext_d, arm_q, run_q;
  logic armed, go;

  assign armed = en_i & (cont_i | arm_q);
  assign run_o = run_q;

  always_comb begin
    unique case (src_e'(src_i))
      SRC_SW:   go = sw_i;
      SRC_EDGE: go = ext_i & ~ext_d;
      SRC_GATE: go = ext_i;
      default:  go = tick_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_d  <= 1'b0;
      ext_d <= 1'b0;
      arm_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      en_d  <= en_i;
      ext_d <= ext_i;
      // single scan arms on enable rise, disarms on completion
      if (!en_i)                arm_q <= 1'b0;
      else if (!en_d)           arm_q <= 1'b1;
      else if (done_i && !cont_i) arm_q <= 1'b0;

      if (!armed || stop_i)                        run_q <= 1'b0;
      else if (src_e'(src_i) == SRC_GATE && !ext_i) run_q <= 1'b0;
      else if (go)                                 run_q <= 1'b1;
    end
  end
endmodule

// File: rtl/adcq_fmt.sv
module adcq_fmt
  import adcq_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int OUT_W = 16
) (
  input  logic [RES_W-1:0] raw_i,
  input  logic [1:0]       fmt_i,
  output logic [OUT_W-1:0] data_o
);
  localparam int PAD_W = OUT_W - RES_W;

  always_comb begin
    unique case (fmt_e'(fmt_i))
      FMT_LS:  data_o = {~raw_i[RES_W-1], raw_i[RES_W-2:0], {PAD_W{1'b0}}};
      FMT_LU:  data_o = {raw_i, {PAD_W{1'b0}}};
      default: data_o = {{PAD_W{1'b0}}, raw_i};
    endcase
  end
endmodule

// File: rtl/adcq_seq.sv
module adcq_seq
  import adcq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int RES_W = 10,
  parameter int OUT_W = 16,
  parameter int TMR_W = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic [AW-1:0]    cmd_addr_i,
  input  logic [CMD_W-1:0] cmd_wdata_i,
  input  logic [AW-1:0]    q2_begin_i,
  input  logic [1:0]       q_en_i,
  input  logic [3:0]       q_src_i,
  input  logic [1:0]       q_cont_i,
  input  logic [1:0]       sw_trig_i,
  input  logic [1:0]       ext_trig_i,
  input  logic [TMR_W-1:0] timer_period_i,
  output logic             conv_req_o,
  output logic [CH_W-1:0]  conv_chan_o,
  output logic [ST_W-1:0]  conv_samp_o,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_data_i,
  input  logic [1:0]       res_fmt_i,
  input  logic [AW-1:0]    res_addr_i,
  output logic [OUT_W-1:0] res_data_o,
  output logic [AW-1:0]    q1_ptr_o,
  output logic [AW-1:0]    q2_ptr_o,
  output logic [1:0]       complete_irq_o,
  output logic [1:0]       pause_irq_o
);
  localparam int NQ = 2;

  cmd_t             tbl   [DEPTH];
  logic [RES_W-1:0] res_q [DEPTH];

  st_e             st_q;
  logic            cur_q;
  logic [CH_W-1:0] chan_q;
  logic [ST_W-1:0] samp_q;
  logic [AW-1:0]   ptr_q [NQ];
  logic [AW-1:0]   beg   [NQ];
  logic [AW-1:0]   last  [NQ];
  logic [NQ-1:0]   run, act, comp_evt, pause_evt;
  logic            sel, tick, done_cur;
  cmd_t            ent_sel, ent_cur;

  assign beg[0]  = '0;
  assign beg[1]  = q2_begin_i;
  assign last[0] = q2_begin_i - AW'(1);
  assign last[1] = AW'(DEPTH - 1);

  always_ff @(posedge clk_i) begin
    if (cmd_we_i) tbl[cmd_addr_i] <= cmd_t'(cmd_wdata_i);
  end

  adcq_timer #(.TMR_W(TMR_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .period_i (timer_period_i),
    .tick_o   (tick)
  );

  for (genvar g = 0; g < NQ; g++) begin : g_q
    adcq_trig u_trig (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (q_en_i[g]),
      .src_i  (q_src_i[2*g +: 2]),
      .cont_i (q_cont_i[g]),
      .sw_i   (sw_trig_i[g]),
      .ext_i  (ext_trig_i[g]),
      .tick_i (tick),
      .stop_i (comp_evt[g] | pause_evt[g]),
      .done_i (comp_evt[g]),
      .run_o  (run[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          ptr_q[g] <= '0;
      else if (!q_en_i[g] || comp_evt[g])   ptr_q[g] <= beg[g];
      else if (done_cur && cur_q == 1'(g))  ptr_q[g] <= ptr_q[g] + AW'(1);
    end
  end

  // queue 1 has no span when the split index is zero
  assign act      = {run[1], run[0] & (|q2_begin_i)};
  assign sel      = ~act[0];
  assign ent_sel  = tbl[ptr_q[sel]];
  assign ent_cur  = tbl[ptr_q[cur_q]];
  assign done_cur = (st_q == ST_CONV) && conv_done_i;

  always_comb begin
    comp_evt  = '0;
    pause_evt = '0;
    if (st_q == ST_IDLE && (|act) && ent_sel.eoq) begin
      comp_evt[sel] = 1'b1;
    end else if (done_cur) begin
      if (ptr_q[cur_q] == last[cur_q]) comp_evt[cur_q]  = 1'b1;
      else if (ent_cur.pause)          pause_evt[cur_q] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q           <= ST_IDLE;
      cur_q          <= 1'b0;
      chan_q         <= '0;
      samp_q         <= '0;
      complete_irq_o <= '0;
      pause_irq_o    <= '0;
    end else begin
      complete_irq_o <= comp_evt;
      pause_irq_o    <= pause_evt;
      unique case (st_q)
        ST_IDLE: if ((|act) && !ent_sel.eoq) begin
          st_q   <= ST_CONV;
          cur_q  <= sel;
          chan_q <= ent_sel.chan;
          samp_q <= ent_sel.samp;
        end
        default: if (conv_done_i) st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (done_cur) res_q[ptr_q[cur_q]] <= conv_data_i;
  end

  adcq_fmt #(.RES_W(RES_W), .OUT_W(OUT_W)) u_fmt (
    .raw_i  (res_q[res_addr_i]),
    .fmt_i  (res_fmt_i),
    .data_o (res_data_o)
  );

  assign conv_req_o  = (st_q == ST_CONV);
  assign conv_chan_o = chan_q;
  assign conv_samp_o = samp_q;
  assign q1_ptr_o    = ptr_q[0];
  assign q2_ptr_o    = ptr_q[1];
endmodule

// File: rtl/adcq_seq_chk.sv
module adcq_seq_chk
  import adcq_pkg::*;
#(
  parameter int AW = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            conv_req_o,
  input logic            conv_done_i,
  input logic [CH_W-1:0] conv_chan_o,
  input logic [ST_W-1:0] conv_samp_o,
  input logic [1:0]      complete_irq_o,
  input logic [1:0]      pause_irq_o,
  input logic [AW-1:0]   q1_ptr_o,
  input logic [AW-1:0]   q2_ptr_o,
  input logic [AW-1:0]   q2_begin_i,
  input logic [1:0]      q_en_i
);
  a_r1_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o && !conv_done_i |=> conv_req_o && $stable(conv_chan_o) && $stable(conv_samp_o));

  a_r4_q1_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    complete_irq_o[0] |-> q1_ptr_o == '0);

  a_r4_q2_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    complete_irq_o[1] && $stable(q2_begin_i) |-> q2_ptr_o == q2_begin_i);

  a_r4_one_complete: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(complete_irq_o));

  a_r5_pause_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_irq_o & complete_irq_o) == 2'b00);

  a_r5_pause_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_irq_o[1] && $past(q_en_i[1]) |-> q2_ptr_o == AW'($past(q2_ptr_o) + AW'(1)));

  a_r12_q1_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_en_i[0] |=> q1_ptr_o == '0);

  a_r12_q2_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_en_i[1] |=> q2_ptr_o == $past(q2_begin_i));
endmodule

bind adcq_seq adcq_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_adcq_seq.sv
module tb_adcq_seq;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [5:0]  cmd_addr = '0;
  logic [6:0]  cmd_wdata = '0;
  logic [5:0]  q2_begin = 6'd16;
  logic [1:0]  q_en = '0;
  logic [3:0]  q_src = '0;
  logic [1:0]  q_cont = '0;
  logic [1:0]  sw_trig = '0;
  logic [1:0]  ext_trig = '0;
  logic [15:0] tper = 16'd99;
  logic        req;
  logic [2:0]  chan;
  logic [1:0]  samp;
  logic        done;
  logic [9:0]  data;
  logic [1:0]  res_fmt = '0;
  logic [5:0]  res_addr = '0;
  logic [15:0] res_data;
  logic [5:0]  q1_ptr, q2_ptr;
  logic [1:0]  cirq, pirq;

  int checks = 0, errors = 0;
  int cyc = 0, nlog = 0, cnt = 0;
  int c_cnt [2];
  int p_cnt [2];
  int lg [0:1023];
  int tq [0:255];
  int ntq = 0;
  logic req_d = 1'b0;

  adcq_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_addr_i(cmd_addr),
    .cmd_wdata_i(cmd_wdata), .q2_begin_i(q2_begin), .q_en_i(q_en), .q_src_i(q_src),
    .q_cont_i(q_cont), .sw_trig_i(sw_trig), .ext_trig_i(ext_trig),
    .timer_period_i(tper), .conv_req_o(req), .conv_chan_o(chan), .conv_samp_o(samp),
    .conv_done_i(done), .conv_data_i(data), .res_fmt_i(res_fmt), .res_addr_i(res_addr),
    .res_data_o(res_data), .q1_ptr_o(q1_ptr), .q2_ptr_o(q2_ptr),
    .complete_irq_o(cirq), .pause_irq_o(pirq)
  );

  always #5 clk = ~clk;

  function automatic int dval(int c, int s);
    return c * 97 + s * 13 + 5;
  endfunction

  function automatic int fmtv(int r, int f);
    case (f)
      1: return ((r ^ 512) << 6);
      2: return (r << 6);
      default: return r;
    endcase
  endfunction

  // behavioural converter stub
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0; data <= '0; cnt <= 0;
    end else if (done) begin
      done <= 1'b0; cnt <= 0;
    end else if (req) begin
      if (cnt == LAT - 1) begin
        done <= 1'b1; data <= 10'(dval(int'(chan), int'(samp))); cnt <= 0;
      end else cnt <= cnt + 1;
    end else cnt <= 0;
  end

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    c_cnt[0] = 0; c_cnt[1] = 0; p_cnt[0] = 0; p_cnt[1] = 0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (req && !req_d) begin lg[nlog % 1024] = int'(samp) * 8 + int'(chan); nlog++; end
      for (int q = 0; q < 2; q++) begin
        if (cirq[q]) c_cnt[q]++;
        if (pirq[q]) p_cnt[q]++;
      end
      if (cirq[0]) begin tq[ntq % 256] = cyc; ntq++; end
    end
    req_d = req;
  end

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input bit eoq, input bit pz, input int s, input int c);
    cmd_we = 1'b1; cmd_addr = 6'(a); cmd_wdata = {eoq, pz, 2'(s), 3'(c)};
    tick(1);
    cmd_we = 1'b0;
  endtask

  task automatic cfg(input int q, input bit en, input int src, input bit cont);
    q_en[q] = en; q_src[2*q +: 2] = 2'(src); q_cont[q] = cont;
  endtask

  task automatic sw(input int q);
    sw_trig[q] = 1'b1; tick(1); sw_trig[q] = 1'b0;
  endtask

  task automatic rd(input int a, input int f, output int v);
    res_addr = 6'(a); res_fmt = 2'(f); #1; v = int'(res_data);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=0 exp=1");
    summary();
  end

  initial begin
    int n0, c0, c1, p, v, n1;
    tick(3);
    // R12 reset state
    chk("R12 req after reset", int'(req), 0);
    chk("R12 irq after reset", int'({cirq, pirq}), 0);
    chk("R12 q1 ptr after reset", int'(q1_ptr), 0);
    rst_n = 1'b1;
    tick(2);
    chk("R12 disabled q2 ptr", int'(q2_ptr), 16);

    // table defaults: entry i -> chan i%8, samp (i/8)%4
    for (int i = 0; i < 64; i++) wr(i, 0, 0, (i / 8) % 4, i % 8);
    for (int i = 0; i < 4; i++) wr(i, 0, 0, i, i + 1);
    wr(4, 1, 0, 0, 0);

    // R1 R3 R4 single sw scan
    cfg(0, 1, 0, 0); tick(2);
    n0 = nlog; c0 = c_cnt[0];
    sw(0); tick(60);
    chk("R3 eoq entry not converted", nlog - n0, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R1 request chan/samp order", lg[(n0 + i) % 1024], i * 8 + i + 1);
      rd(i, 0, v);
      chk("R1 result at entry index", v, dval(i + 1, i));
    end
    chk("R4 complete pulse", c_cnt[0] - c0, 1);
    chk("R4 q1 ptr reload", int'(q1_ptr), 0);

    // R6 single scan ignores retrigger
    n0 = nlog; c0 = c_cnt[0];
    sw(0); tick(60);
    chk("R6 no scan after single complete", nlog - n0, 0);
    chk("R6 no complete after single", c_cnt[0] - c0, 0);
    cfg(0, 0, 0, 0); tick(2); cfg(0, 1, 0, 0); tick(2);
    sw(0); tick(60);
    chk("R6 rearm after enable cycle", nlog - n0, 4);

    // R3 span end without eoq
    cfg(0, 0, 0, 0); q2_begin = 6'd3; tick(2);
    cfg(0, 1, 0, 0); tick(2);
    n0 = nlog; c0 = c_cnt[0];
    sw(0); tick(60);
    chk("R3 span end conversions", nlog - n0, 3);
    chk("R3 span end complete", c_cnt[0] - c0, 1);
    chk("R3 span end ptr", int'(q1_ptr), 0);
    cfg(0, 0, 0, 0); q2_begin = 6'd16; tick(2);

    // R5 pause subqueues on q2
    wr(16, 0, 0, 0, 0); wr(17, 0, 1, 0, 1); wr(18, 0, 0, 0, 2);
    wr(19, 0, 0, 0, 3); wr(20, 1, 0, 0, 0);
    cfg(1, 1, 0, 0); tick(2);
    n0 = nlog; c1 = c_cnt[1]; p = p_cnt[1];
    sw(1); tick(60);
    chk("R5 converts up to pause", nlog - n0, 2);
    chk("R5 pause pulse", p_cnt[1] - p, 1);
    chk("R5 no complete at pause", c_cnt[1] - c1, 0);
    chk("R5 ptr at next entry", int'(q2_ptr), 18);
    sw(1); tick(60);
    chk("R5 second subqueue", nlog - n0, 4);
    chk("R5 complete after subqueue", c_cnt[1] - c1, 1);
    chk("R4 q2 ptr reload", int'(q2_ptr), 16);
    cfg(1, 0, 0, 0); tick(2);

    // R7 continuous sw
    cfg(0, 1, 0, 1); tick(2);
    n0 = nlog; c0 = c_cnt[0];
    sw(0); tick(60); sw(0); tick(60);
    chk("R7 continuous rescans", c_cnt[0] - c0, 2);
    chk("R7 continuous conversions", nlog - n0, 8);
    cfg(0, 0, 0, 0); tick(2);

    // R8 edge trigger
    cfg(0, 1, 1, 1); tick(2);
    n0 = nlog; c0 = c_cnt[0];
    ext_trig[0] = 1'b1; tick(150);
    chk("R8 held level one scan", c_cnt[0] - c0, 1);
    chk("R8 held level conversions", nlog - n0, 4);
    ext_trig[0] = 1'b0; tick(2); ext_trig[0] = 1'b1; tick(60);
    chk("R8 new edge new scan", c_cnt[0] - c0, 2);
    ext_trig[0] = 1'b0; cfg(0, 0, 0, 0); tick(2);

    // R9 gate
    for (int i = 16; i < 48; i++) wr(i, 0, 0, (i / 8) % 4, i % 8);
    wr(48, 1, 0, 0, 0);
    cfg(1, 1, 2, 1); tick(2);
    n0 = nlog;
    ext_trig[1] = 1'b1; tick(22); ext_trig[1] = 1'b0; tick(20);
    p = int'(q2_ptr); n1 = nlog;
    chk("R9 gate stopped inside span", int'(p > 16 && p < 48), 1);
    chk("R9 ptr counts conversions", nlog - n0, p - 16);
    tick(60);
    chk("R9 ptr holds gate low", int'(q2_ptr), p);
    chk("R9 no requests gate low", nlog, n1);
    ext_trig[1] = 1'b1; tick(3);
    chk("R9 resumes at held entry", lg[n1 % 1024], p % 32);
    ext_trig[1] = 1'b0; tick(20); cfg(1, 0, 0, 0); tick(2);

    // R10 timer
    n0 = ntq;
    cfg(0, 1, 3, 1); tick(520);
    chk("R10 timer scans seen", int'(ntq - n0 >= 4), 1);
    for (int k = 1; k < 4; k++)
      chk("R10 timer interval", tq[(n0 + k) % 256] - tq[(n0 + k - 1) % 256], 100);
    cfg(0, 0, 0, 0); tick(30);

    // R11 priority with q2 resume
    for (int i = 16; i < 24; i++) wr(i, 0, 0, 1, i - 16);
    wr(24, 1, 0, 0, 0);
    for (int i = 0; i < 3; i++) wr(i, 0, 0, 3, 5 + i);
    wr(3, 1, 0, 0, 0);
    cfg(0, 1, 0, 0); cfg(1, 1, 0, 0); tick(2);
    n0 = nlog; c0 = c_cnt[0]; c1 = c_cnt[1];
    sw(1);
    for (int k = 0; k < 200 && nlog < n0 + 3; k++) tick(1);
    sw(0); tick(100);
    for (int i = 0; i < 11; i++) begin
      int e;
      e = (i < 3) ? 8 + i : (i < 6) ? 29 + (i - 3) : 8 + (i - 3);
      chk("R11 service order", lg[(n0 + i) % 1024], e);
    end
    chk("R11 both complete", (c_cnt[0] - c0) + (c_cnt[1] - c1), 2);
    cfg(0, 0, 0, 0); cfg(1, 0, 0, 0); tick(2);

    // R2 format sweep over all chan/samp codes
    q2_begin = 6'd32;
    for (int i = 0; i < 32; i++) wr(i, 0, 0, i / 8, i % 8);
    tick(2);
    cfg(0, 1, 0, 0); tick(2);
    c0 = c_cnt[0];
    sw(0); tick(250);
    chk("R3 32-entry span complete", c_cnt[0] - c0, 1);
    for (int i = 0; i < 32; i++)
      for (int f = 0; f < 4; f++) begin
        rd(i, f, v);
        chk("R2 result format", v, fmtv(dval(i % 8, i / 8), f));
      end

    summary();
  end
endmodule